// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible register file for an I/O address translation unit. It holds the settings the translator needs: an enable bit, the size of the translation window, and the page-table base. It also holds the flush registers, the fault status and fault address registers, arbiter and per-slot settings, and a mask identification word. Each register keeps only its writable bits and forces its fixed bits to their set values. The block drives the window start, the page-table base and the enable to the translator. It receives fault captures back from the translator and raises a level interrupt for them.

Software reaches the block over a 32-bit bus with a valid/ready handshake. A front-end state machine has two states. ST_IDLE holds ready high and accepts any request. ST_RESP presents read data for one cycle with ready low. The machine has three transitions:
- T_RD_ACCEPT: ST_IDLE to ST_RESP, when a read is accepted.
- T_RESP_DONE: ST_RESP to ST_IDLE, taken unconditionally.
- T_STAY: ST_IDLE to ST_IDLE, on a write or when there is no request.

A write takes effect at the clock edge that accepts it.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset the registers read as follows.
  - Control reads VERSION in bits [31:24] and 0 below.
  - Fault status reads 0x00800000.
  - Arbiter enable reads 0x00000003.
  - Arbitration enable reads 0x00000008.
  - Mask ID reads 0x23000000.
  - Every other register reads 0.
  - win_start, pt_base, xlat_en and irq are 0.
- R2: A write to control (0x0000) keeps only the data bits in 0x0000001D and ORs in VERSION at bits [31:24]. xlat_en follows bit 0 of the stored value.
- R3: A control write sets win_start to the bitwise inverse of ((16 MB << n) - 1), where n is written bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. win_start changes only on a control write.
- R4: A write to the page-table base (0x0004) keeps only the bits in 0x07FFFC00, and pt_base shows the stored value. The flush registers (0x0014 and 0x0018) store all 32 written bits.
- R5: A write to arbiter enable (0x1008) keeps the bits in 0x801F000F and forces bit 0 to 1.
- R6: A write to fault status (0x1000) keeps the bits in 0xFF0FFFFF and forces bit 23 to 1. A write to fault address (0x1004) stores all 32 bits.
- R7: The four per-slot registers at 0x1010, 0x1014, 0x1018 and 0x101C each keep the bits in 0x00010003, independently of one another. A write to arbitration enable (0x2000) keeps the bits in 0x001F0000 and ORs in 0x00000008.
- R8: A write to mask ID (0x3018) ORs written bits [23:0] into the stored value and never clears a bit.
- R9: A cycle with flt_cap high loads fault address from flt_addr. It loads fault status with 0xC0820000, plus bit 18 (0x00040000) when flt_is_read is high. irq is high from the next cycle.
- R10: An accepted read or write of fault status or fault address drives irq low from the next cycle, unless flt_cap is high in the same cycle.
- R11: When flt_cap coincides with an accepted write to fault status or fault address, the captured values are stored and irq is high. A read accepted in that cycle returns the value held before the capture.
- R12: Unaligned addresses and offsets not listed above read as 0. Writes to them change no register.
- R13: In ST_IDLE req_ready is high. After an accepted read, rsp_valid is high with the data for exactly the next cycle, and req_ready is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flt_cap | input | 1 | Fault capture strobe from the translator |
| flt_is_read | input | 1 | Faulting access was a read |
| flt_addr | input | 32 | Faulting page address |
| xlat_en | output | 1 | Translation enable |
| win_start | output | 32 | First address of the translation window |
| pt_base | output | 32 | Page-table base |
| irq | output | 1 | Level fault interrupt |

## Verification
A fault capture from the translator can fall in the same cycle as a software read or write of the fault status or fault address register. The bench provokes this by raising flt_cap on the same falling edge that presents such a bus request. It does this in directed cases and at random within the mixed stimulus. The result is judged against a bench model in which the capture overrides the write and sets the interrupt. In that model, a read accepted in the same cycle returns the value held before the capture.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
    localparam int ADDR_W       = 14;
    localparam int DATA_W       = 32;
    localparam int N_SLOTS      = 4;
    localparam int SLOT_W       = $clog2(N_SLOTS);
    localparam int RANGE_W      = 3;
    localparam int WIN_MIN_LOG2 = 24;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 14'h0000;
    localparam logic [ADDR_W-1:0] OFF_BASE   = 14'h0004;
    localparam logic [ADDR_W-1:0] OFF_TLBF   = 14'h0014;
    localparam logic [ADDR_W-1:0] OFF_PGF    = 14'h0018;
    localparam logic [ADDR_W-1:0] OFF_FSR    = 14'h1000;
    localparam logic [ADDR_W-1:0] OFF_FAR    = 14'h1004;
    localparam logic [ADDR_W-1:0] OFF_AER    = 14'h1008;
    localparam logic [ADDR_W-1:0] OFF_SLOT0  = 14'h1010;
    localparam logic [ADDR_W-1:0] OFF_ARBEN  = 14'h2000;
    localparam logic [ADDR_W-1:0] OFF_MASKID = 14'h3018;

    localparam logic [DATA_W-1:0] CTRL_KEEP   = 32'h0000_001D;
    localparam logic [DATA_W-1:0] BASE_KEEP   = 32'h07FF_FC00;
    localparam logic [DATA_W-1:0] AER_KEEP    = 32'h801F_000F;
    localparam logic [DATA_W-1:0] AER_FORCE   = 32'h0000_0001;
    localparam logic [DATA_W-1:0] FSR_KEEP    = 32'hFF0F_FFFF;
    localparam logic [DATA_W-1:0] FSR_FORCE   = 32'h0080_0000;
    localparam logic [DATA_W-1:0] SLOT_KEEP   = 32'h0001_0003;
    localparam logic [DATA_W-1:0] ARBEN_KEEP  = 32'h001F_0000;
    localparam logic [DATA_W-1:0] ARBEN_FORCE = 32'h0000_0008;
    localparam logic [DATA_W-1:0] MASKID_KEEP = 32'h00FF_FFFF;

    localparam logic [DATA_W-1:0] AER_RST     = 32'h0000_0003;
    localparam logic [DATA_W-1:0] MASKID_RST  = 32'h2300_0000;

    localparam logic [DATA_W-1:0] FSR_CAPTURE = 32'hC082_0000;
    localparam logic [DATA_W-1:0] FSR_RD_BIT  = 32'h0004_0000;

    typedef enum logic [3:0] {
        K_NONE, K_CTRL, K_BASE, K_TLBF, K_PGF, K_FSR, K_FAR,
        K_AER, K_SLOT, K_ARBEN, K_MASKID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [SLOT_W-1:0] slot;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t          s;
        logic [ADDR_W-1:0] rel;
        s.kind = K_NONE;
        s.slot = '0;
        rel    = a - OFF_SLOT0;
        if (a[1:0] == 2'b00) begin
            if (a == OFF_CTRL)        s.kind = K_CTRL;
            else if (a == OFF_BASE)   s.kind = K_BASE;
            else if (a == OFF_TLBF)   s.kind = K_TLBF;
            else if (a == OFF_PGF)    s.kind = K_PGF;
            else if (a == OFF_FSR)    s.kind = K_FSR;
            else if (a == OFF_FAR)    s.kind = K_FAR;
            else if (a == OFF_AER)    s.kind = K_AER;
            else if (a == OFF_ARBEN)  s.kind = K_ARBEN;
            else if (a == OFF_MASKID) s.kind = K_MASKID;
            else if (a >= OFF_SLOT0 && rel < ADDR_W'(4 * N_SLOTS)) begin
                s.kind = K_SLOT;
                s.slot = rel[SLOT_W+1:2];
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/xlat_bus_fsm.sv
module xlat_bus_fsm
    import xlat_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] rd_value,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output reg_sel_t          acc_sel,
    output logic              acc_wr,
    output logic              acc_rd
);
    typedef enum logic [0:0] {ST_IDLE, ST_RESP} bus_state_e;

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;  // T_RD_ACCEPT
            ST_RESP: state_d = ST_IDLE;                               // T_RESP_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        acc_sel   = decode_addr(req_addr);
        acc_wr    = req_valid && req_ready && req_write;
        acc_rd    = req_valid && req_ready && !req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (acc_rd) rsp_rdata <= rd_value;
    end
endmodule

// File: rtl/xlat_window_dec.sv
module xlat_window_dec
    import xlat_regs_pkg::*;
#(
    parameter int MIN_LOG2 = WIN_MIN_LOG2
) (
    input  logic [RANGE_W-1:0] code,
    output logic [DATA_W-1:0]  start
);
    localparam logic [DATA_W-1:0] MIN_SIZE = DATA_W'(1) << MIN_LOG2;

    logic [DATA_W-1:0] size;

    always_comb begin
        size  = MIN_SIZE << code;
        start = ~(size - DATA_W'(1));
    end
endmodule

// File: rtl/xlat_reg_bank.sv
module xlat_reg_bank
    import xlat_regs_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  reg_sel_t          acc_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] new_win,
    input  logic              flt_cap,
    input  logic              flt_is_read,
    input  logic [DATA_W-1:0] flt_addr,
    output logic [DATA_W-1:0] rd_value,
    output logic              xlat_en,
    output logic [DATA_W-1:0] win_start,
    output logic [DATA_W-1:0] pt_base,
    output logic              irq
);
    localparam logic [DATA_W-1:0] VER_BITS = {VERSION, 24'h0};

    logic [DATA_W-1:0] ctrl_q, base_q, tlbf_q, pgf_q, fsr_q, far_q;
    logic [DATA_W-1:0] aer_q, arben_q, maskid_q, win_q;
    logic [DATA_W-1:0] slot_rd [N_SLOTS];
    logic              irq_q;

    function automatic logic hit(input reg_sel_t s, input reg_kind_e k);
        return s.kind == k;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= VER_BITS;
            base_q   <= '0;
            tlbf_q   <= '0;
            pgf_q    <= '0;
            aer_q    <= AER_RST;
            arben_q  <= ARBEN_FORCE;
            maskid_q <= MASKID_RST;
            win_q    <= '0;
        end else if (acc_wr) begin
            if (hit(acc_sel, K_CTRL)) begin
                ctrl_q <= (wdata & CTRL_KEEP) | VER_BITS;
                win_q  <= new_win;
            end
            if (hit(acc_sel, K_BASE))   base_q   <= wdata & BASE_KEEP;
            if (hit(acc_sel, K_TLBF))   tlbf_q   <= wdata;
            if (hit(acc_sel, K_PGF))    pgf_q    <= wdata;
            if (hit(acc_sel, K_AER))    aer_q    <= (wdata & AER_KEEP) | AER_FORCE;
            if (hit(acc_sel, K_ARBEN))  arben_q  <= (wdata & ARBEN_KEEP) | ARBEN_FORCE;
            if (hit(acc_sel, K_MASKID)) maskid_q <= maskid_q | (wdata & MASKID_KEEP);
        end
    end

    // fault registers: translator capture has priority over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr_q <= FSR_FORCE;
            far_q <= '0;
            irq_q <= 1'b0;
        end else if (flt_cap) begin
            fsr_q <= FSR_CAPTURE | (flt_is_read ? FSR_RD_BIT : '0);
            far_q <= flt_addr;
            irq_q <= 1'b1;
        end else begin
            if (acc_wr && hit(acc_sel, K_FSR)) fsr_q <= (wdata & FSR_KEEP) | FSR_FORCE;
            if (acc_wr && hit(acc_sel, K_FAR)) far_q <= wdata;
            if ((acc_wr || acc_rd) && (hit(acc_sel, K_FSR) || hit(acc_sel, K_FAR)))
                irq_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (acc_wr && hit(acc_sel, K_SLOT) && acc_sel.slot == SLOT_W'(g))
                q <= wdata & SLOT_KEEP;
        end
        assign slot_rd[g] = q;
    end

    always_comb begin
        unique case (acc_sel.kind)
            K_CTRL:   rd_value = ctrl_q;
            K_BASE:   rd_value = base_q;
            K_TLBF:   rd_value = tlbf_q;
            K_PGF:    rd_value = pgf_q;
            K_FSR:    rd_value = fsr_q;
            K_FAR:    rd_value = far_q;
            K_AER:    rd_value = aer_q;
            K_SLOT:   rd_value = slot_rd[acc_sel.slot];
            K_ARBEN:  rd_value = arben_q;
            K_MASKID: rd_value = maskid_q;
            default:  rd_value = '0;
        endcase
    end

    assign xlat_en   = ctrl_q[0];
    assign win_start = win_q;
    assign pt_base   = base_q;
    assign irq       = irq_q;
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
    import xlat_regs_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [13:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              flt_cap,
    input  logic              flt_is_read,
    input  logic [31:0]       flt_addr,
    output logic              xlat_en,
    output logic [31:0]       win_start,
    output logic [31:0]       pt_base,
    output logic              irq
);
    reg_sel_t          acc_sel;
    logic              acc_wr, acc_rd;
    logic [DATA_W-1:0] rd_value, new_win;

    xlat_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .rd_value  (rd_value),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .acc_sel   (acc_sel),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd)
    );

    xlat_window_dec #(.MIN_LOG2(WIN_MIN_LOG2)) u_win (
        .code  (req_wdata[4:2]),
        .start (new_win)
    );

    xlat_reg_bank #(.VERSION(VERSION)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .acc_sel     (acc_sel),
        .wdata       (req_wdata),
        .new_win     (new_win),
        .flt_cap     (flt_cap),
        .flt_is_read (flt_is_read),
        .flt_addr    (flt_addr),
        .rd_value    (rd_value),
        .xlat_en     (xlat_en),
        .win_start   (win_start),
        .pt_base     (pt_base),
        .irq         (irq)
    );
endmodule

// File: rtl/xlat_ctl_regs_chk.sv
module xlat_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [13:0] req_addr,
    input logic        rsp_valid,
    input logic        flt_cap,
    input logic [31:0] win_start,
    input logic [31:0] pt_base,
    input logic        irq
);
    logic acc, flt_reg;
    assign acc     = req_valid && req_ready;
    assign flt_reg = (req_addr == 14'h1000) || (req_addr == 14'h1004);

    // R13
    rd_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |=> (rsp_valid && !req_ready));

    // R13
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    cap_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_cap |=> irq);

    // R10
    access_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && flt_reg && !flt_cap) |=> !irq);

    // R3
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && req_write && req_addr == 14'h0000) |=> $stable(win_start));

    // R3
    win_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start == 32'h0) || (win_start[31] && win_start[23:0] == 24'h0));

    // R4
    base_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_base & ~32'h07FF_FC00) == 32'h0);
endmodule

bind xlat_ctl_regs xlat_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .flt_cap   (flt_cap),
    .win_start (win_start),
    .pt_base   (pt_base),
    .irq       (irq)
);

// File: tb/sim_xlat_ctl_regs.sv
`timescale 1ns/1ps
module sim_xlat_ctl_regs;
    localparam logic [7:0] VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        flt_cap = 1'b0, flt_is_read = 1'b0;
    logic [31:0] flt_addr = '0;
    logic        req_ready, rsp_valid, xlat_en, irq;
    logic [31:0] rsp_rdata, win_start, pt_base;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xlat_ctl_regs #(.VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flt_cap(flt_cap),
        .flt_is_read(flt_is_read), .flt_addr(flt_addr), .xlat_en(xlat_en),
        .win_start(win_start), .pt_base(pt_base), .irq(irq)
    );

    // bench model
    logic [31:0] m_ctrl, m_base, m_tlbf, m_pgf, m_fsr, m_far, m_aer, m_arben, m_mid, m_win;
    logic [31:0] m_slot [4];
    logic        m_irq;

    function automatic logic [31:0] win_of(input logic [2:0] n);
        logic [31:0] sz = 32'h0100_0000 << n;
        return ~(sz - 32'd1);
    endfunction

    function automatic logic [31:0] mread(input logic [13:0] a);
        case (a)
            14'h0000: return m_ctrl;
            14'h0004: return m_base;
            14'h0014: return m_tlbf;
            14'h0018: return m_pgf;
            14'h1000: return m_fsr;
            14'h1004: return m_far;
            14'h1008: return m_aer;
            14'h1010: return m_slot[0];
            14'h1014: return m_slot[1];
            14'h1018: return m_slot[2];
            14'h101C: return m_slot[3];
            14'h2000: return m_arben;
            14'h3018: return m_mid;
            default:  return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [13:0] a);
        case (a)
            14'h0000: return "R2";
            14'h0004, 14'h0014, 14'h0018: return "R4";
            14'h1000, 14'h1004: return "R6";
            14'h1008: return "R5";
            14'h1010, 14'h1014, 14'h1018, 14'h101C, 14'h2000: return "R7";
            14'h3018: return "R8";
            default:  return "R12";
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = {VER, 24'h0}; m_base = 0; m_tlbf = 0; m_pgf = 0;
        m_fsr = 32'h0080_0000; m_far = 0; m_aer = 32'h3; m_arben = 32'h8;
        m_mid = 32'h2300_0000; m_win = 0; m_irq = 0;
        for (int i = 0; i < 4; i++) m_slot[i] = 0;
    endtask

    task automatic model_write(input logic [13:0] a, input logic [31:0] d);
        case (a)
            14'h0000: begin m_ctrl = (d & 32'h1D) | {VER, 24'h0}; m_win = win_of(d[4:2]); end
            14'h0004: m_base = d & 32'h07FF_FC00;
            14'h0014: m_tlbf = d;
            14'h0018: m_pgf = d;
            14'h1000: begin m_fsr = (d & 32'hFF0F_FFFF) | 32'h0080_0000; m_irq = 0; end
            14'h1004: begin m_far = d; m_irq = 0; end
            14'h1008: m_aer = (d & 32'h801F_000F) | 32'h1;
            14'h1010: m_slot[0] = d & 32'h0001_0003;
            14'h1014: m_slot[1] = d & 32'h0001_0003;
            14'h1018: m_slot[2] = d & 32'h0001_0003;
            14'h101C: m_slot[3] = d & 32'h0001_0003;
            14'h2000: m_arben = (d & 32'h001F_0000) | 32'h8;
            14'h3018: m_mid = m_mid | (d & 32'h00FF_FFFF);
            default: ;
        endcase
    endtask

    task automatic model_cap(input logic rd, input logic [31:0] fa);
        m_fsr = 32'hC082_0000 | (rd ? 32'h0004_0000 : 32'h0);
        m_far = fa;
        m_irq = 1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_outs();
        chk("R3 win_start", win_start, m_win);
        chk("R4 pt_base", pt_base, m_base);
        chk("R2 xlat_en", {31'b0, xlat_en}, {31'b0, m_ctrl[0]});
        chk("R9 R10 irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_write(input logic [13:0] a, input logic [31:0] d,
                            input logic cap, input logic rd, input logic [31:0] fa);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        flt_cap = cap; flt_is_read = rd; flt_addr = fa;
        chk("R13 ready idle", {31'b0, req_ready}, 32'h1);
        @(posedge clk); @(negedge clk);
        req_valid = 0; flt_cap = 0;
        model_write(a, d);
        if (cap) model_cap(rd, fa);
        chk_outs();
    endtask

    task automatic do_read(input logic [13:0] a,
                           input logic cap, input logic rd, input logic [31:0] fa);
        logic [31:0] exp;
        exp = mread(a);
        req_valid = 1; req_write = 0; req_addr = a;
        flt_cap = cap; flt_is_read = rd; flt_addr = fa;
        @(posedge clk); @(negedge clk);
        req_valid = 0; flt_cap = 0;
        if (a == 14'h1000 || a == 14'h1004) m_irq = 0;
        if (cap) model_cap(rd, fa);
        chk("R13 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        chk("R13 ready low in resp", {31'b0, req_ready}, 32'h0);
        chk(req_of(a), rsp_rdata, exp);
        @(posedge clk); @(negedge clk);
        chk("R13 rsp one cycle", {31'b0, rsp_valid}, 32'h0);
        chk_outs();
    endtask

    task automatic do_cap(input logic rd, input logic [31:0] fa);
        flt_cap = 1; flt_is_read = rd; flt_addr = fa;
        @(posedge clk); @(negedge clk);
        flt_cap = 0;
        model_cap(rd, fa);
        chk_outs();
    endtask

    logic [13:0] pool [21] = '{14'h0000, 14'h0004, 14'h0014, 14'h0018, 14'h1000,
        14'h1004, 14'h1008, 14'h1010, 14'h1014, 14'h1018, 14'h101C, 14'h2000,
        14'h3018, 14'h0008, 14'h0010, 14'h1020, 14'h2004, 14'h3014, 14'h0001,
        14'h1006, 14'h3FFC};

    initial begin
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1 win_start", win_start, 32'h0);
        chk("R1 pt_base", pt_base, 32'h0);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < 21; i++) do_read(pool[i], 0, 0, 0);   // R1 reset values

        // R3 directed range codes
        do_write(14'h0000, 32'h0000_0001, 0, 0, 0);
        chk("R3 code0", win_start, 32'hFF00_0000);
        do_write(14'h0000, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R3 code7", win_start, 32'h8000_0000);
        do_read(14'h0000, 0, 0, 0);                                // R2
        do_write(14'h0000, 32'h0000_000C, 0, 0, 0);
        chk("R3 code3", win_start, 32'hF800_0000);
        do_write(14'h0004, 32'h0000_0000, 0, 0, 0);
        chk("R3 hold on other write", win_start, 32'hF800_0000);

        // R8 accumulation
        do_write(14'h3018, 32'hFF00_00F0, 0, 0, 0);
        do_write(14'h3018, 32'h0000_0000, 0, 0, 0);
        do_read(14'h3018, 0, 0, 0);
        chk("R8 accumulate", mread(14'h3018), 32'h2300_00F0);

        // R9 capture and R10 clearing
        do_cap(1, 32'h1234_5000);
        do_read(14'h1000, 0, 0, 0);
        chk("R9 status read", m_fsr, 32'hC086_0000);
        do_cap(0, 32'hABCD_E000);
        do_read(14'h1004, 0, 0, 0);
        do_cap(0, 32'h0000_1000);
        do_write(14'h1004, 32'h5555_5555, 0, 0, 0);
        do_cap(1, 32'h0000_2000);
        do_write(14'h1000, 32'hFFFF_FFFF, 0, 0, 0);
        do_read(14'h1000, 0, 0, 0);

        // R11 coincident capture and software access
        do_write(14'h1000, 32'h0000_0000, 1, 0, 32'h7777_7000);
        chk("R11 irq after coincident write", {31'b0, irq}, 32'h1);
        do_read(14'h1000, 0, 0, 0);
        do_cap(1, 32'h1111_1000);
        do_write(14'h1004, 32'h0000_0000, 1, 1, 32'h2222_2000);
        do_read(14'h1004, 1, 0, 32'h3333_3000);
        chk("R11 irq after coincident read", {31'b0, irq}, 32'h1);
        do_read(14'h1004, 0, 0, 0);

        // R12 ignored offsets: write then read every listed register
        do_write(14'h0016, 32'hFFFF_FFFF, 0, 0, 0);
        do_write(14'h1006, 32'hFFFF_FFFF, 0, 0, 0);
        do_write(14'h3FFC, 32'hFFFF_FFFF, 0, 0, 0);
        for (int i = 0; i < 21; i++) do_read(pool[i], 0, 0, 0);

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int          k   = int'($urandom_range(20, 0));
            int          op  = int'($urandom_range(9, 0));
            logic        cap = ($urandom_range(7, 0) == 0);
            logic        rd  = $urandom_range(1, 0) == 1;
            logic [31:0] d   = $urandom;
            logic [31:0] fa  = $urandom & 32'hFFFF_F000;
            if (op < 5)      do_write(pool[k], d, cap, rd, fa);
            else if (op < 9) do_read(pool[k], cap, rd, fa);
            else             do_cap(rd, fa);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule